// File: doc/BRIEF.md
# Microcoded Multicycle Operate Stage

This block is the execute step of an in-order pipeline. It holds its own input registers for an opcode, a valid flag and two 16-bit operands, A and B. It also drives a result register and a forwarded opcode register toward the stages that follow. Logical and arithmetic operations pass through the ALU and a one-bit shifter in a single clock, and the stage takes a new instruction on every cycle.

Multiply and divide run as 16-step sequences on the same ALU. A small sequencer inside the stage drives these sequences. The result register feeds back into one ALU input. The second operand stays frozen in its input register, because the stage raises `stall` to hold the upstream stage. While the sequence runs, the result is marked invalid toward downstream.

The stage samples its inputs at a rising clock edge only while `stall` is low. The result of a sampled instruction reaches `outR`/`outValid` one further edge later. Multi-step operations add sixteen cycles to this.

Top module: `opstage_top`

## Requirements
- R1: When a simple instruction (opcodes 0 to 4) has been sampled, `stall` stays low, and its result and `outValid`=1 appear after the next rising edge. A new instruction can be sampled on every edge.
- R2: The simple opcodes compute modulo 2^16 as follows: 0 gives A&B, 1 gives A|B, 2 gives ~A, 3 gives A+B and 4 gives A-B.
- R3: A sampled slot with `inValid` low, or with any opcode other than 0 to 4, 8 or 9, produces `outValid`=0 and does not stall.
- R4: Opcode 8 returns the low 16 bits of the unsigned product A*B. From the cycle the instruction is sampled, `stall` is high for exactly 16 cycles. The result appears with `outValid`=1 one edge after `stall` falls, which is 17 cycles after sampling.
- R5: Opcode 9 returns the unsigned quotient floor(A/B) with the same timing as R4.
- R6: Opcode 9 with B=0 returns 0xFFFF, with normal timing and no other effect.
- R7: `outValid` is 0 in every cycle that follows a cycle with `stall` high.
- R8: While `stall` is high, the stage ignores `inValid`, `inOp`, `inA` and `inB`. The running operation finishes with the operands it sampled.
- R9: An instruction presented during the last step of a sequence, when `stall` is low, is sampled on that same edge, so no bubble is inserted.
- R10: Whenever `outValid` is 1, `outOp` carries the opcode of the instruction that produced `outR`.
- R11: While the active-low reset `rstN` is low, `stall` is 0 and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream slot holds a real instruction |
| inOp | input | 4 | Upstream opcode |
| inA | input | 16 | Upstream operand A |
| inB | input | 16 | Upstream operand B |
| stall | output | 1 | Upstream must hold; the stage will not sample |
| outValid | output | 1 | `outR` holds a finished result |
| outOp | output | 4 | Forwarded opcode |
| outR | output | 16 | Result register |

## Verification
A step counter that is off by one changes the width of the `stall` pulse, so the fault appears within the first multi-step instruction. It also shifts the result by one bit or cuts it short, so the value at `outR` is wrong at the end of that instruction. A sequencer that does not return to its idle state shows up as `stall` staying high into the next slot. A wrong recirculation select or a wrong gating bit corrupts the product or quotient. That error only shows at the final step, about 17 cycles after issue, so the bench compares every cycle against a behavioural model. The operand patterns are chosen so that each quotient and product bit matters.

// File: rtl/opstage_pkg.sv
package opstage_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 4;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;

  localparam logic [OP_W-1:0] OP_AND = 4'h0;
  localparam logic [OP_W-1:0] OP_OR  = 4'h1;
  localparam logic [OP_W-1:0] OP_NOT = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD = 4'h3;
  localparam logic [OP_W-1:0] OP_SUB = 4'h4;
  localparam logic [OP_W-1:0] OP_MUL = 4'h8;
  localparam logic [OP_W-1:0] OP_DIV = 4'h9;

  typedef enum logic [2:0] {
    FN_ZERO, FN_AND, FN_OR, FN_NOT, FN_ADD, FN_SUB, FN_MACC, FN_DSTEP
  } aluFnE;

  typedef struct packed {
    aluFnE            fn;       // ALU function
    logic             shl;      // shifter: shift ALU output left by one
    logic             recirc;   // y operand comes from result register
    logic [IDX_W-1:0] bitIdx;   // multiplier bit that gates the addend
    logic             loadQ;    // load quotient shift register from A
    logic             selQuot;  // result register takes the quotient
    logic             resValid; // this cycle finishes a result
  } ctrlStrobesT;
endpackage

// File: rtl/opstage_ctrl.sv
module opstage_ctrl
  import opstage_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            irValid,
  input  logic [OP_W-1:0] irOp,
  output logic            stall,
  output ctrlStrobesT     strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV} seqStateE;

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  seqStateE         stateQ, stateNext;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic             lastStep;

  assign lastStep = (cntQ == LAST_STEP);

  always_comb begin
    strobes   = '{fn: FN_ZERO, default: '0};
    stall     = 1'b0;
    stateNext = stateQ;
    cntNext   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        cntNext = '0;
        if (irValid) begin
          case (irOp)
            OP_AND: begin strobes.fn = FN_AND; strobes.resValid = 1'b1; end
            OP_OR:  begin strobes.fn = FN_OR;  strobes.resValid = 1'b1; end
            OP_NOT: begin strobes.fn = FN_NOT; strobes.resValid = 1'b1; end
            OP_ADD: begin strobes.fn = FN_ADD; strobes.resValid = 1'b1; end
            OP_SUB: begin strobes.fn = FN_SUB; strobes.resValid = 1'b1; end
            OP_MUL: begin stall = 1'b1; stateNext = ST_MUL; end
            OP_DIV: begin stall = 1'b1; strobes.loadQ = 1'b1; stateNext = ST_DIV; end
            default: ;
          endcase
        end
      end
      ST_MUL, ST_DIV: begin
        strobes.recirc = 1'b1;
        strobes.bitIdx = IDX_W'(DATA_W - 1) - cntQ[IDX_W-1:0];
        if (stateQ == ST_MUL) begin
          strobes.fn  = FN_MACC;
          strobes.shl = !lastStep;
        end else begin
          strobes.fn      = FN_DSTEP;
          strobes.selQuot = lastStep;
        end
        if (lastStep) begin
          strobes.resValid = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          stall   = 1'b1;
          cntNext = cntQ + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateNext;
      cntQ   <= cntNext;
    end
  end
endmodule

// File: rtl/opstage_dp.sv
module opstage_dp
  import opstage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadIn,
  input  logic              inValid,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  ctrlStrobesT       strobes,
  output logic              irValid,
  output logic [OP_W-1:0]   irOp,
  output logic              outValid,
  output logic [OP_W-1:0]   outOp,
  output logic [DATA_W-1:0] outR
);
  logic [DATA_W-1:0] aQ, bQ, rQ, qQ;
  logic [DATA_W-1:0] yIn, aluOut, shOut, rNext, qNext, divSub;
  logic [DATA_W:0]   divPart;
  logic              gateBit, divGe;

  assign yIn     = strobes.recirc ? rQ : bQ;
  assign gateBit = bQ[strobes.bitIdx];
  assign divPart = {rQ, qQ[DATA_W-1]};
  assign divGe   = (divPart >= {1'b0, bQ});
  assign divSub  = divPart[DATA_W-1:0] - bQ;

  always_comb begin
    unique case (strobes.fn)
      FN_AND:   aluOut = aQ & yIn;
      FN_OR:    aluOut = aQ | yIn;
      FN_NOT:   aluOut = ~aQ;
      FN_ADD:   aluOut = aQ + yIn;
      FN_SUB:   aluOut = aQ - yIn;
      FN_MACC:  aluOut = yIn + (gateBit ? aQ : '0);
      FN_DSTEP: aluOut = divGe ? divSub : divPart[DATA_W-1:0];
      default:  aluOut = '0;
    endcase
    shOut = strobes.shl ? (aluOut << 1) : aluOut;
    rNext = strobes.selQuot ? {qQ[DATA_W-2:0], divGe} : shOut;
    if (strobes.loadQ)              qNext = aQ;
    else if (strobes.fn == FN_DSTEP) qNext = {qQ[DATA_W-2:0], divGe};
    else                            qNext = qQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irValid  <= 1'b0;
      irOp     <= '0;
      aQ       <= '0;
      bQ       <= '0;
      rQ       <= '0;
      qQ       <= '0;
      outValid <= 1'b0;
      outOp    <= '0;
    end else begin
      if (loadIn) begin
        irValid <= inValid;
        irOp    <= inOp;
        aQ      <= inA;
        bQ      <= inB;
      end
      rQ       <= rNext;
      qQ       <= qNext;
      outValid <= strobes.resValid;
      outOp    <= irOp;
    end
  end

  assign outR = rQ;
endmodule

// File: rtl/opstage_top.sv
module opstage_top
  import opstage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              stall,
  output logic              outValid,
  output logic [OP_W-1:0]   outOp,
  output logic [DATA_W-1:0] outR
);
  ctrlStrobesT     strobes;
  logic            irValid;
  logic [OP_W-1:0] irOp;

  opstage_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .irValid(irValid), .irOp(irOp),
    .stall(stall), .strobes(strobes)
  );

  opstage_dp dp_i (
    .clk(clk), .rstN(rstN), .loadIn(!stall), .inValid(inValid), .inOp(inOp),
    .inA(inA), .inB(inB), .strobes(strobes), .irValid(irValid), .irOp(irOp),
    .outValid(outValid), .outOp(outOp), .outR(outR)
  );
endmodule

// File: rtl/opstage_chk.sv
module opstage_chk
  import opstage_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            stall,
  input logic            outValid,
  input logic [OP_W-1:0] outOp,
  input logic            irValid,
  input logic [OP_W-1:0] irOp
);
  logic [CNT_W:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)      runLen <= '0;
    else if (stall) runLen <= runLen + 1'b1;
    else            runLen <= '0;
  end

  assert_stall_hides_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !outValid);

  assert_hold_operands_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(irOp) && $stable(irValid)));

  assert_simple_one_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && irValid && (irOp <= OP_SUB)) |=> outValid);

  assert_stall_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (runLen < (CNT_W + 1)'(DATA_W)));

  assert_end_gives_result_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |=> outValid);

  assert_legal_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outOp <= OP_SUB) || (outOp == OP_MUL) || (outOp == OP_DIV)));
endmodule

bind opstage_top opstage_chk chk_i (
  .clk(clk), .rstN(rstN), .stall(stall), .outValid(outValid), .outOp(outOp),
  .irValid(irValid), .irOp(irOp)
);

// File: tb/opstage_top_tb_top.sv
module opstage_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  inOp = '0;
  logic [15:0] inA = '0, inB = '0;
  logic        stall, outValid;
  logic [3:0]  outOp;
  logic [15:0] outR;

  int checks = 0, fails = 0;
  bit done = 0;

  opstage_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inA(inA), .inB(inB),
    .stall(stall), .outValid(outValid), .outOp(outOp), .outR(outR)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int          mLeft = 0;
  logic        mIrV = 0;
  logic [3:0]  mIrOp = 0;
  logic [15:0] mA = 0, mB = 0;
  logic        eV = 0;
  logic [15:0] eR = 0;
  logic [3:0]  eOp = 0;
  string       eTag = "R1";
  int          nIssued = 0;

  function automatic bit isMulti(logic [3:0] op);
    return (op == 4'h8) || (op == 4'h9);
  endfunction

  function automatic bit expStall();
    if (mLeft == 0) return mIrV && isMulti(mIrOp);
    return mLeft != 1;
  endfunction

  task automatic check(string tag, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pickInstr(output logic v, output logic [3:0] op,
                           output logic [15:0] a, output logic [15:0] b);
    v = 1; a = $urandom; b = $urandom;
    case (nIssued)
      0:  begin op = 4'h0; a = 16'hF0F0; b = 16'h3CC3; end
      1:  begin op = 4'h1; a = 16'hF0F0; b = 16'h3CC3; end
      2:  begin op = 4'h2; a = 16'h1234; end
      3:  begin op = 4'h3; a = 16'hFFFF; b = 16'h0002; end
      4:  begin op = 4'h4; a = 16'h0003; b = 16'h0005; end
      5:  begin op = 4'h3; v = 0; end
      6:  begin op = 4'h5; end
      7:  begin op = 4'h8; a = 16'h1234; b = 16'h0100; end
      8:  begin op = 4'h3; a = 16'h0007; b = 16'h0009; end // R9 back-to-back
      9:  begin op = 4'h8; a = 16'hFFFF; b = 16'hFFFF; end
      10: begin op = 4'h9; a = 16'd1000; b = 16'd7; end
      11: begin op = 4'h9; a = 16'd5; b = 16'd0; end
      12: begin op = 4'h9; a = 16'd3; b = 16'd10; end
      13: begin op = 4'h9; a = 16'hFFFF; b = 16'd1; end
      14: begin op = 4'h8; a = 16'h0000; b = 16'hBEEF; end
      15: begin op = 4'hF; end
      default: begin
        case ($urandom % 11)
          0: op = 4'h0; 1: op = 4'h1; 2: op = 4'h2; 3: op = 4'h3; 4: op = 4'h4;
          5: op = 4'h8; 6: op = 4'h9; 7: op = 4'h8; 8: op = 4'h9;
          9: op = 4'hA; default: begin op = 4'h3; v = 0; end
        endcase
        if ($urandom % 8 == 0) b = 0;
        if ($urandom % 8 == 0) b = 16'(b % 16);
      end
    endcase
    nIssued++;
  endtask

  task automatic advance(bit stallNow, logic dv, logic [3:0] dop,
                         logic [15:0] da, logic [15:0] db);
    logic [31:0] prod;
    if (mLeft == 0) begin
      if (mIrV && isMulti(mIrOp)) begin
        mLeft = 16; eV = 0;
      end else if (mIrV && mIrOp <= 4'h4) begin
        eV = 1; eOp = mIrOp; eTag = "R1 R2";
        case (mIrOp)
          4'h0: eR = mA & mB;
          4'h1: eR = mA | mB;
          4'h2: eR = ~mA;
          4'h3: eR = mA + mB;
          default: eR = mA - mB;
        endcase
      end else eV = 0;
    end else begin
      mLeft--;
      if (mLeft == 0) begin
        eV = 1; eOp = mIrOp;
        if (mIrOp == 4'h8) begin
          prod = mA * mB; eR = prod[15:0]; eTag = "R4 R8";
        end else if (mB == 0) begin
          eR = 16'hFFFF; eTag = "R6";
        end else begin
          eR = mA / mB; eTag = "R5 R8";
        end
      end else eV = 0;
    end
    if (!stallNow) begin
      mIrV = dv; mIrOp = dop; mA = da; mB = db;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", stall === 1'b0, "stall in reset", stall, 0);
    check("R11", outValid === 1'b0, "outValid in reset", outValid, 0);
    rstN = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      bit es;
      logic dv; logic [3:0] dop; logic [15:0] da, db;
      es = expStall();
      check(mLeft != 0 ? "R4" : "R1", stall === es, "stall", stall, es);
      check(eV ? eTag : "R3 R7", outValid === eV, "outValid", outValid, eV);
      if (eV) begin
        check(eTag, outR === eR, "outR", outR, eR);
        check("R10", outOp === eOp, "outOp", outOp, eOp);
      end
      if (!es) begin
        pickInstr(dv, dop, da, db);
      end else begin
        // R8: garbage while stalled must not disturb the running operation
        dv = 1'($urandom); dop = 4'($urandom); da = $urandom; db = $urandom;
      end
      inValid = dv; inOp = dop; inA = da; inB = db;
      advance(es, dv, dop, da, db);
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule